// File: doc/BRIEF.md
# Element-Width Register File

This block is a general-purpose register file of 128 registers, 64 bits each, that is treated internally as one flat store of 1024 bytes. Every port addresses an *element* rather than a whole register: it supplies a register number, an element width (8, 16, 32 or 64 bits), an element offset and a scalar/vector flag. The element's first byte sits at `register*8 + offset*(width/8)`. A narrow element therefore packs into consecutive bytes of the register, and an element past the end of a register continues into the next one.

Two combinational read ports return the selected element zero-extended into the low bits of a 64-bit word. One write port stores the low bytes of its data word into exactly the bytes the element covers. It uses per-byte enables, so the rest of the register keeps its old contents. A loop sequencer that walks an element index from 0 to VL-1 uses these ports to run one instruction over a vector of registers, at any element width, without a separate vector register file.

Top module: `ewrf_top`

## Requirements
- R1: After a synchronous active-high reset every byte of the store reads as zero.
- R2: The width code selects 8 bits (0), 16 bits (1), 32 bits (2) or 64 bits (3). A read returns the element in bits [W-1:0] of its output, and all higher bits are zero.
- R3: An element starts at byte `reg*8 + offset*(W/8)`, with byte k of the element at the next higher byte address. An element that passes the last byte of a register continues into the following register. Addresses wrap modulo 1024, so the byte after register 127 is byte 0 of register 0.
- R4: When the scalar flag of a port is 1, the element offset is taken as 0 whatever value is supplied.
- R5: A write changes only the W/8 bytes of its element, taking them from the low bytes of the write data. Every other byte, including the unused part of the same register, keeps its value.
- R6: A 64-bit scalar write replaces all eight bytes of the addressed register.
- R7: A write takes effect at the clock edge and is seen by reads from the next cycle on. A read in the same cycle as an overlapping write returns the old bytes.
- R8: The two read ports are independent. Both may address the same or different elements, widths and offsets in one cycle.
- R9: With the write enable low, no byte of the store changes, whatever is on the other write inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write enable |
| wrReg | input | 7 | Write register number |
| wrWidth | input | 2 | Write element width code |
| wrOffset | input | 7 | Write element offset |
| wrScalar | input | 1 | Write port scalar flag |
| wrData | input | 64 | Write data, element in the low bytes |
| rdRegA | input | 7 | Read port A register number |
| rdWidthA | input | 2 | Read port A element width code |
| rdOffsetA | input | 7 | Read port A element offset |
| rdScalarA | input | 1 | Read port A scalar flag |
| rdDataA | output | 64 | Read port A element, zero-extended |
| rdRegB | input | 7 | Read port B register number |
| rdWidthB | input | 2 | Read port B element width code |
| rdOffsetB | input | 7 | Read port B element offset |
| rdScalarB | input | 1 | Read port B scalar flag |
| rdDataB | output | 64 | Read port B element, zero-extended |

## Verification
Two things can meet in one cycle here. One is a write whose bytes overlap what a read port is returning. The other is both read ports landing on the same bytes through different widths or offsets. The sweep drives random writes and two random reads in every cycle over a small register window, so byte overlaps between all three ports occur often. Each read is compared, before the edge, with a byte model that does not yet hold that cycle's write. Directed steps also read a register in the very cycle it is rewritten, then read it again one cycle later, so the old value must appear first and the new value second.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;
  localparam int REG_COUNT   = 128;
  localparam int REG_BYTES   = 8;
  localparam int OFF_W       = 7;
  localparam int RD_PORTS    = 2;
  localparam int ALL_PORTS   = RD_PORTS + 1;

  localparam int DATA_W      = REG_BYTES * 8;
  localparam int REG_W       = $clog2(REG_COUNT);
  localparam int TOTAL_BYTES = REG_COUNT * REG_BYTES;
  localparam int ADDR_W      = $clog2(TOTAL_BYTES);
  localparam int LANE_W      = $clog2(REG_BYTES);
  localparam int LEN_W       = LANE_W + 1;
  localparam int WSEL_W      = $clog2(LANE_W + 1);
  localparam logic [WSEL_W-1:0] WSEL_FULL = WSEL_W'(LANE_W);

  // Strobes handed from the control side to the byte store.
  typedef struct packed {
    logic                                wrStrobe;
    logic [ADDR_W-1:0]                   wrBase;
    logic [LEN_W-1:0]                    wrLen;
    logic [RD_PORTS-1:0][ADDR_W-1:0]     rdBase;
    logic [RD_PORTS-1:0][LEN_W-1:0]      rdLen;
  } rfStrobe_t;
endpackage

// File: rtl/ewrf_locate.sv
module ewrf_locate
  import ewrf_pkg::*;
(
  input  logic [REG_W-1:0]  regNum,
  input  logic [WSEL_W-1:0] widthSel,
  input  logic [OFF_W-1:0]  elemOff,
  input  logic              isScalar,
  output logic [ADDR_W-1:0] byteBase,
  output logic [LEN_W-1:0]  byteLen
);
  logic [ADDR_W-1:0] regBase;
  logic [ADDR_W-1:0] effOff;
  logic [ADDR_W-1:0] offBytes;

  always_comb begin
    regBase  = ADDR_W'(regNum) << LANE_W;
    // scalar-tagged operands always use element 0
    effOff   = isScalar ? '0 : ADDR_W'(elemOff);
    offBytes = effOff << widthSel;
    // truncation to ADDR_W gives the wrap past the top register
    byteBase = regBase + offBytes;
    byteLen  = LEN_W'(1) << widthSel;
  end
endmodule

// File: rtl/ewrf_ctrl.sv
module ewrf_ctrl
  import ewrf_pkg::*;
(
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrReg,
  input  logic [WSEL_W-1:0] wrWidth,
  input  logic [OFF_W-1:0]  wrOffset,
  input  logic              wrScalar,
  input  logic [REG_W-1:0]  rdRegA,
  input  logic [WSEL_W-1:0] rdWidthA,
  input  logic [OFF_W-1:0]  rdOffsetA,
  input  logic              rdScalarA,
  input  logic [REG_W-1:0]  rdRegB,
  input  logic [WSEL_W-1:0] rdWidthB,
  input  logic [OFF_W-1:0]  rdOffsetB,
  input  logic              rdScalarB,
  output rfStrobe_t         strobe
);
  // slot 0 is the write port, slots 1.. are read ports
  logic [REG_W-1:0]  regSel  [ALL_PORTS];
  logic [WSEL_W-1:0] wSel    [ALL_PORTS];
  logic [OFF_W-1:0]  offSel  [ALL_PORTS];
  logic              scSel   [ALL_PORTS];
  logic [ADDR_W-1:0] baseOut [ALL_PORTS];
  logic [LEN_W-1:0]  lenOut  [ALL_PORTS];

  assign regSel[0] = wrReg;
  assign wSel[0]   = wrWidth;
  assign offSel[0] = wrOffset;
  assign scSel[0]  = wrScalar;
  assign regSel[1] = rdRegA;
  assign wSel[1]   = rdWidthA;
  assign offSel[1] = rdOffsetA;
  assign scSel[1]  = rdScalarA;
  assign regSel[2] = rdRegB;
  assign wSel[2]   = rdWidthB;
  assign offSel[2] = rdOffsetB;
  assign scSel[2]  = rdScalarB;

  for (genvar p = 0; p < ALL_PORTS; p++) begin : g_loc
    ewrf_locate u_loc (
      .regNum   (regSel[p]),
      .widthSel (wSel[p]),
      .elemOff  (offSel[p]),
      .isScalar (scSel[p]),
      .byteBase (baseOut[p]),
      .byteLen  (lenOut[p])
    );
  end

  always_comb begin
    strobe.wrStrobe = wrEn;
    strobe.wrBase   = baseOut[0];
    strobe.wrLen    = lenOut[0];
    for (int p = 0; p < RD_PORTS; p++) begin
      strobe.rdBase[p] = baseOut[p+1];
      strobe.rdLen[p]  = lenOut[p+1];
    end
  end
endmodule

// File: rtl/ewrf_store.sv
module ewrf_store
  import ewrf_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  rfStrobe_t                        strobe,
  input  logic [DATA_W-1:0]                wrData,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rdData
);
  logic [7:0]        byteMem  [TOTAL_BYTES];
  logic              byteHit  [TOTAL_BYTES];
  logic [LANE_W-1:0] byteLane [TOTAL_BYTES];

  // per-byte write enable: byte lies inside [base, base+len) modulo store size
  always_comb begin
    for (int j = 0; j < TOTAL_BYTES; j++) begin
      logic [ADDR_W-1:0] rel;
      rel         = ADDR_W'(j) - strobe.wrBase;
      byteHit[j]  = strobe.wrStrobe && (rel < ADDR_W'(strobe.wrLen));
      byteLane[j] = rel[LANE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < TOTAL_BYTES; j++) byteMem[j] <= '0;
    end else begin
      for (int j = 0; j < TOTAL_BYTES; j++) begin
        if (byteHit[j]) byteMem[j] <= wrData[{byteLane[j], 3'b000} +: 8];
      end
    end
  end

  // gather up to REG_BYTES consecutive bytes, zero above the element
  always_comb begin
    for (int p = 0; p < RD_PORTS; p++) begin
      for (int k = 0; k < REG_BYTES; k++) begin
        logic [ADDR_W-1:0] addr;
        addr = strobe.rdBase[p] + ADDR_W'(k);
        if (LEN_W'(k) < strobe.rdLen[p]) rdData[p][k*8 +: 8] = byteMem[addr];
        else                             rdData[p][k*8 +: 8] = 8'h00;
      end
    end
  end
endmodule

// File: rtl/ewrf_top.sv
module ewrf_top
  import ewrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrReg,
  input  logic [WSEL_W-1:0] wrWidth,
  input  logic [OFF_W-1:0]  wrOffset,
  input  logic              wrScalar,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REG_W-1:0]  rdRegA,
  input  logic [WSEL_W-1:0] rdWidthA,
  input  logic [OFF_W-1:0]  rdOffsetA,
  input  logic              rdScalarA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [REG_W-1:0]  rdRegB,
  input  logic [WSEL_W-1:0] rdWidthB,
  input  logic [OFF_W-1:0]  rdOffsetB,
  input  logic              rdScalarB,
  output logic [DATA_W-1:0] rdDataB
);
  rfStrobe_t                       strobe;
  logic [RD_PORTS-1:0][DATA_W-1:0] rdData;

  ewrf_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrReg     (wrReg),
    .wrWidth   (wrWidth),
    .wrOffset  (wrOffset),
    .wrScalar  (wrScalar),
    .rdRegA    (rdRegA),
    .rdWidthA  (rdWidthA),
    .rdOffsetA (rdOffsetA),
    .rdScalarA (rdScalarA),
    .rdRegB    (rdRegB),
    .rdWidthB  (rdWidthB),
    .rdOffsetB (rdOffsetB),
    .rdScalarB (rdScalarB),
    .strobe    (strobe)
  );

  ewrf_store u_store (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
endmodule

// File: rtl/ewrf_checker.sv
module ewrf_checker
  import ewrf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [REG_W-1:0]  wrReg,
  input logic [WSEL_W-1:0] wrWidth,
  input logic [OFF_W-1:0]  wrOffset,
  input logic              wrScalar,
  input logic [DATA_W-1:0] wrData,
  input logic [REG_W-1:0]  rdRegA,
  input logic [WSEL_W-1:0] rdWidthA,
  input logic [OFF_W-1:0]  rdOffsetA,
  input logic              rdScalarA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [REG_W-1:0]  rdRegB,
  input logic [WSEL_W-1:0] rdWidthB,
  input logic [OFF_W-1:0]  rdOffsetB,
  input logic              rdScalarB,
  input logic [DATA_W-1:0] rdDataB
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rdDataA == '0 && rdDataB == '0));

  // R2
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rdWidthA != WSEL_FULL) |-> ((rdDataA >> (8 << rdWidthA)) == '0));

  // R4
  scalar_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rdScalarA && rdScalarB && rdRegA == rdRegB && rdWidthA == rdWidthB)
      |-> (rdDataA == rdDataB));

  // R6
  full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrScalar && wrWidth == WSEL_FULL) |=>
      ((rdScalarA && rdWidthA == WSEL_FULL && rdRegA == $past(wrReg))
        -> (rdDataA == $past(wrData))));

  // R8
  port_match_chk: assert property (@(posedge clk) disable iff (rst)
    (rdRegA == rdRegB && rdWidthA == rdWidthB && rdOffsetA == rdOffsetB &&
     rdScalarA == rdScalarB) |-> (rdDataA == rdDataB));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wrEn) && $stable(rdRegA) && $stable(rdWidthA) &&
     $stable(rdOffsetA) && $stable(rdScalarA)) |-> $stable(rdDataA));
endmodule

bind ewrf_top ewrf_checker u_chk (.*);

// File: tb/test_ewrf_top.sv
module test_ewrf_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [6:0]  wrReg;
  logic [1:0]  wrWidth;
  logic [6:0]  wrOffset;
  logic        wrScalar;
  logic [63:0] wrData;
  logic [6:0]  rdRegA, rdRegB;
  logic [1:0]  rdWidthA, rdWidthB;
  logic [6:0]  rdOffsetA, rdOffsetB;
  logic        rdScalarA, rdScalarB;
  logic [63:0] rdDataA, rdDataB;

  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 0;
  logic [7:0] model [1024];

  always #5 clk = ~clk;

  ewrf_top i_ewrf_top (.*);

  function automatic int baseOf(int r, int w, int off, bit sc);
    return (r * 8 + (sc ? 0 : off) * (1 << w)) % 1024;
  endfunction

  function automatic logic [63:0] expRead(int r, int w, int off, bit sc);
    logic [63:0] e = '0;
    int b = baseOf(r, w, off, sc);
    for (int k = 0; k < (1 << w); k++) e[k*8 +: 8] = model[(b + k) % 1024];
    return e;
  endfunction

  task automatic compare(string tag, string port, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s port %s: got %h expected %h", tag, port, act, exp);
    end
  endtask

  // inputs are set after a falling edge; check, then let the rising edge write
  task automatic doCycle(string tag);
    #2;
    compare(tag, "A", rdDataA, expRead(rdRegA, rdWidthA, rdOffsetA, rdScalarA));
    compare(tag, "B", rdDataB, expRead(rdRegB, rdWidthB, rdOffsetB, rdScalarB));
    @(posedge clk);
    #1;
    if (wrEn) begin
      int b = baseOf(wrReg, wrWidth, wrOffset, wrScalar);
      for (int k = 0; k < (1 << wrWidth); k++) model[(b + k) % 1024] = wrData[k*8 +: 8];
    end
    @(negedge clk);
  endtask

  task automatic setWr(bit en, int r, int w, int off, bit sc, logic [63:0] d);
    wrEn = en; wrReg = 7'(r); wrWidth = 2'(w); wrOffset = 7'(off); wrScalar = sc; wrData = d;
  endtask

  task automatic setRdA(int r, int w, int off, bit sc);
    rdRegA = 7'(r); rdWidthA = 2'(w); rdOffsetA = 7'(off); rdScalarA = sc;
  endtask

  task automatic setRdB(int r, int w, int off, bit sc);
    rdRegB = 7'(r); rdWidthB = 2'(w); rdOffsetB = 7'(off); rdScalarB = sc;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    for (int j = 0; j < 1024; j++) model[j] = 8'h00;
    rst = 1'b1;
    setWr(0, 0, 0, 0, 0, '0);
    setRdA(0, 3, 0, 1);
    setRdB(0, 3, 0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every register reads zero after reset
    for (int r = 0; r < 128; r++) begin
      setRdA(r, 3, 0, 1);
      setRdB(127 - r, 3, 0, 1);
      doCycle("R1");
    end

    // R6: full scalar overwrite, then R5: three 16-bit elements keep top 16 bits
    setWr(1, 10, 3, 9, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    setRdA(10, 3, 0, 1); setRdB(10, 3, 0, 1);
    doCycle("R6");
    for (int i = 0; i < 3; i++) begin
      setWr(1, 10, 1, i, 0, 64'h1234_5678_9ABC_0000 | 64'(16'h1111 * (i + 1)));
      doCycle("R5");
    end
    setWr(0, 0, 0, 0, 0, '0);
    doCycle("R5");
    compare("R5", "top16", rdDataA, 64'hFFFF_3333_2222_1111);

    // R5: 8-bit vector of length 7 leaves the eighth byte alone
    setWr(1, 20, 3, 0, 1, 64'hA5A5_A5A5_A5A5_A5A5);
    setRdA(20, 3, 0, 1); setRdB(20, 0, 7, 0);
    doCycle("R5");
    for (int i = 0; i < 7; i++) begin
      setWr(1, 20, 0, i, 0, 64'(8'h10 + i));
      doCycle("R5");
    end
    setWr(0, 0, 0, 0, 0, '0);
    doCycle("R5");
    compare("R5", "byte7", rdDataA, 64'hA516_1514_1312_1110);

    // R3: 32-bit element at offset 3 of reg 30 lands in reg 31 upper half
    setWr(1, 30, 2, 3, 0, 64'h0000_0000_DEAD_BEEF);
    setRdA(31, 3, 0, 1); setRdB(30, 2, 3, 0);
    doCycle("R3");
    setWr(0, 0, 0, 0, 0, '0);
    doCycle("R3");
    compare("R3", "spill", rdDataA, 64'hDEAD_BEEF_0000_0000);

    // R3: element past register 127 wraps to register 0
    setWr(1, 127, 3, 1, 0, 64'h0F1E_2D3C_4B5A_6978);
    setRdA(0, 3, 0, 1); setRdB(127, 3, 1, 0);
    doCycle("R3");
    setWr(0, 0, 0, 0, 0, '0);
    doCycle("R3");
    compare("R3", "wrap", rdDataA, 64'h0F1E_2D3C_4B5A_6978);

    // R4: scalar write ignores offset 5 and fills element 0
    setWr(1, 40, 1, 5, 1, 64'h0000_0000_0000_C0DE);
    setRdA(40, 1, 9, 1); setRdB(40, 3, 0, 1);
    doCycle("R4");
    setWr(0, 0, 0, 0, 0, '0);
    doCycle("R4");
    compare("R4", "scalar", rdDataB, 64'h0000_0000_0000_C0DE);

    // R7: read in the write cycle sees old value, next cycle sees new
    setWr(1, 50, 3, 0, 1, 64'h0000_0000_0000_0001);
    setRdA(50, 3, 0, 1); setRdB(50, 0, 0, 0);
    doCycle("R7");
    setWr(1, 50, 3, 0, 1, 64'h7777_6666_5555_4444);
    #2 compare("R7", "old", rdDataA, 64'h0000_0000_0000_0001);
    #1 doCycle("R7");
    setWr(0, 0, 0, 0, 0, '0);
    #2 compare("R7", "new", rdDataA, 64'h7777_6666_5555_4444);
    #1 doCycle("R7");

    // R9: disabled write with live data changes nothing
    setWr(0, 50, 3, 0, 1, 64'hBAD0_BAD0_BAD0_BAD0);
    doCycle("R9");
    doCycle("R9");
    compare("R9", "hold", rdDataA, 64'h7777_6666_5555_4444);

    // R2/R8: random mixed traffic over a small register window
    for (int n = 0; n < 3000; n++) begin
      int wa = $urandom % 4;
      int wb = $urandom % 4;
      int ww = $urandom % 4;
      setWr(($urandom % 4) != 0, 120 + ($urandom % 8), ww, $urandom % 16,
            ($urandom % 4) == 0, {$urandom, $urandom});
      setRdA(120 + ($urandom % 8), wa, $urandom % 16, ($urandom % 4) == 0);
      if ((n % 5) == 0) setRdB(rdRegA, rdWidthA, rdOffsetA, rdScalarA);
      else setRdB(120 + ($urandom % 8), wb, $urandom % 16, ($urandom % 4) == 0);
      doCycle((n % 2) ? "R8" : "R2");
    end

    finishRun();
  end
endmodule